// File: doc/BRIEF.md
# Serial Port Bit-Rate Tick Generator

This block produces two single-cycle enables for a serial port. The sampling tick tells a receiver when to take an oversampled look at its line. The bit tick marks each bit period. All logic runs on the master clock. The block does not generate any clocks of its own.

A two-bit select chooses the input that drives the counting. It can be the master clock itself, the master clock divided by a fixed prescaler, or an external serial clock pin. The pin passes through a synchronizer, and each of its rising edges counts once. A 16-bit divisor then divides the selected source.

In asynchronous mode, the divisor output is the sampling tick. A second counter divides the sampling tick by 16 or 8 to make the bit tick. In synchronous mode, the divisor output is the bit tick and no sampling ticks are made. Any change to the configuration inputs restarts every counter, so timing after a change is exact.

Top module: `baud_tick_gen`

## Requirements
- R1: `src_sel` encodes the source: 0 is every master clock cycle, 1 is one cycle in every PRESCALE cycles (default 8), and 3 is each synchronized rising edge of `ext_clk`.
- R2: In asynchronous mode (`sync_mode`=0), one bit tick is produced every 8×(2−`over_x8`)×`cd` source enables. That is 16×`cd` when `over_x8`=0 and 8×`cd` when `over_x8`=1.
- R3: In asynchronous mode, a sampling tick is produced every `cd` source enables. Each bit tick coincides with the 16th sampling tick (`over_x8`=0) or the 8th sampling tick (`over_x8`=1).
- R4: Rate examples on the master clock source: `cd`=6 with `over_x8`=0 gives a bit every 96 cycles (38,400 bit/s at 3.6864 MHz). `cd`=8 gives a bit every 128 cycles (39,062.5 bit/s at 5 MHz). `cd`=1 with `over_x8`=1 gives the fastest rate, one bit every 8 cycles.
- R5: `ext_clk` passes through a two-flop synchronizer. If the pin rises during master cycle j, its enable is active in cycle j+2, and any tick that enable completes appears in that cycle. The pin must stay high and low for more than one master cycle each, and it must toggle at no more than the master frequency divided by 4.5.
- R6: In synchronous mode (`sync_mode`=1), a bit tick is produced every `cd` source enables, and `sample_tick` stays low.
- R7: When `cd`=0, neither output ever pulses.
- R8: Source code 2 is reserved and produces no ticks.
- R9: A change to `src_sel`, `cd`, `over_x8` or `sync_mode` in cycle k suppresses any tick in cycle k and restarts all counters. With the master clock source, the first tick then comes in cycle k+P, where P is the full period.
- R10: Both outputs are low during reset, and every tick lasts one master cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Source select (0 master, 1 prescaled, 2 reserved, 3 external pin) |
| cd | input | DIV_W | Divisor; 0 stops all ticks |
| over_x8 | input | 1 | 0: bit = 16 samples, 1: bit = 8 samples |
| sync_mode | input | 1 | 1: divisor output is the bit tick directly |
| ext_clk | input | 1 | External serial clock pin, asynchronous |
| sample_tick | output | 1 | Receiver sampling enable (asynchronous mode only) |
| bit_tick | output | 1 | Bit-rate enable |

## Verification
The divisor counter and the configuration restart can act in the same cycle. A new setting can arrive in exactly the cycle where the old setting was about to fire a tick. The bench provokes this by waiting until the cycle the scoreboard predicts for the next old tick and changing the divisor there. It then judges that no tick appears in that cycle and that the first new tick lands one full new period later. The sampling and bit ticks also coincide by design. Their alignment is judged by counting sampling ticks over each run and by a property that ties every asynchronous bit tick to a sampling tick.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    SRC_MCK = 2'd0,
    SRC_PRE = 2'd1,
    SRC_RSV = 2'd2,
    SRC_EXT = 2'd3
  } baud_src_e;

  localparam int OS_W = 4;

  // Last value of the oversampling counter before it wraps.
  function automatic logic [OS_W-1:0] os_last(input logic x8);
    return x8 ? OS_W'(7) : OS_W'(15);
  endfunction

  // Divider terminal count for a given divisor.
  function automatic logic [31:0] div_last(input logic [31:0] cd_val);
    return cd_val - 32'd1;
  endfunction
endpackage

// File: rtl/baud_src_sel.sv
module baud_src_sel
  import baud_pkg::*;
#(
  parameter int PRESCALE = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      restart,
  input  baud_src_e src,
  input  logic      ext_pin,
  output logic      src_en
);
  logic pre_en;
  logic ext_rise;
  logic [2:0] sync_sh;

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PC_W = $clog2(PRESCALE);
      localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRESCALE - 1);
      logic [PC_W-1:0] pc;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pc <= '0;
        else if (restart)        pc <= '0;
        else if (pc == PC_LAST)  pc <= '0;
        else                     pc <= pc + 1'b1;
      end
      assign pre_en = (pc == PC_LAST);
    end else begin : g_nopre
      assign pre_en = 1'b1;
    end
  endgenerate

  // Two synchronizer stages plus one history stage for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_sh <= '0;
    else        sync_sh <= {sync_sh[1:0], ext_pin};
  end
  assign ext_rise = sync_sh[1] & ~sync_sh[2];

  always_comb begin
    unique case (src)
      SRC_MCK: src_en = 1'b1;
      SRC_PRE: src_en = pre_en;
      SRC_EXT: src_en = ext_rise;
      default: src_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider
  import baud_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             src_en,
  input  logic [DIV_W-1:0] cd,
  output logic             div_tick
);
  logic [DIV_W-1:0] cnt;
  logic             run;
  logic             hit;

  assign run = src_en && (cd != '0);
  assign hit = run && (cnt == DIV_W'(div_last(32'(cd))));
  assign div_tick = hit && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (hit)     cnt <= '0;
    else if (run)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/baud_oversamp.sv
module baud_oversamp
  import baud_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic div_tick,
  input  logic x8,
  output logic os_wrap
);
  logic [OS_W-1:0] os_cnt;

  assign os_wrap = div_tick && (os_cnt == os_last(x8));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        os_cnt <= '0;
    else if (restart)  os_cnt <= '0;
    else if (os_wrap)  os_cnt <= '0;
    else if (div_tick) os_cnt <= os_cnt + 1'b1;
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int PRESCALE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] cd,
  input  logic             over_x8,
  input  logic             sync_mode,
  input  logic             ext_clk,
  output logic             sample_tick,
  output logic             bit_tick
);
  localparam int CFG_W = DIV_W + 4;

  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic restart;
  logic src_en;
  logic div_tick;
  logic os_wrap;

  assign cfg_now = {src_sel, over_x8, sync_mode, cd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_now;
  end
  assign restart = (cfg_now != cfg_q);

  baud_src_sel #(.PRESCALE(PRESCALE)) u_src (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .src(baud_src_e'(src_sel)), .ext_pin(ext_clk), .src_en(src_en)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .src_en(src_en), .cd(cd), .div_tick(div_tick)
  );

  baud_oversamp u_os (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .div_tick(div_tick), .x8(over_x8), .os_wrap(os_wrap)
  );

  assign sample_tick = div_tick && !sync_mode;
  assign bit_tick    = sync_mode ? div_tick : os_wrap;
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk
  import baud_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       src_sel,
  input logic [DIV_W-1:0] cd,
  input logic             sync_mode,
  input logic             sample_tick,
  input logic             bit_tick,
  input logic             restart,
  input logic             src_en
);
  a_r7_cd_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cd == '0) |-> (!sample_tick && !bit_tick));

  a_r8_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_RSV) |-> (!sample_tick && !bit_tick));

  a_r6_sync_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> !sample_tick);

  a_r3_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && bit_tick) |-> sample_tick);

  a_r9_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (!sample_tick && !bit_tick));

  a_r5_ext_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_EXT && src_en) |=> !src_en);

  a_r10_sample_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_MCK && cd > DIV_W'(1) && sample_tick) |=> !sample_tick);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .cd(cd),
  .sync_mode(sync_mode), .sample_tick(sample_tick), .bit_tick(bit_tick),
  .restart(restart), .src_en(src_en)
);

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic [15:0] cd = 16'd0;
  logic over_x8 = 1'b0;
  logic sync_mode = 1'b0;
  logic ext_clk = 1'b0;
  logic sample_tick, bit_tick;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .cd(cd),
    .over_x8(over_x8), .sync_mode(sync_mode), .ext_clk(ext_clk),
    .sample_tick(sample_tick), .bit_tick(bit_tick)
  );

  always #(CLK_NS/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int exp_q[$];
  string req_q[$];
  string cur_req = "R10";
  int s_cnt = 0, s_end = 0;

  task automatic check(bit ok, string r, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  // Monitor: pops the scoreboard on each bit tick, counts sampling ticks.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (bit_tick) begin
        if (exp_q.size() == 0) check(1'b0, {cur_req, " unexpected bit tick"}, cyc, -1);
        else begin
          int e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(cyc == e, r, cyc, e);
        end
      end
      if (sample_tick && cyc <= s_end) s_cnt++;
    end
  end

  function automatic int bit_cycles(int s, int c, bit o, bit y);
    int base;
    base = (s == 1) ? 8 : 1;
    return base * c * (y ? 1 : (o ? 8 : 16));
  endfunction

  task automatic at_cyc(int c);
    while (cyc < c) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_run(int n, bit o, bit y, string r, int last);
    while (cyc <= last) @(negedge clk);
    check(exp_q.size() == 0, {r, " missing bit ticks"}, exp_q.size(), 0);
    check(s_cnt == (y ? 0 : n * (o ? 8 : 16)), {r, " sample tick count"}, s_cnt,
          y ? 0 : n * (o ? 8 : 16));
  endtask

  // Driver: apply a setting, push expected bit-tick cycles.
  task automatic run_cfg(int s, int c, bit o, bit y, int n, string r, output int last);
    int k, m;
    @(posedge clk);
    #1;
    src_sel = s[1:0]; cd = c[15:0]; over_x8 = o; sync_mode = y;
    k = cyc;
    m = bit_cycles(s, c, o, y);
    cur_req = r;
    s_cnt = 0;
    for (int i = 1; i <= n; i++) begin
      exp_q.push_back(k + i * m);
      req_q.push_back(r);
    end
    last = (n == 0) ? k + 300 : k + n * m;
    s_end = last;
    finish_run(n, o, y, r, last);
  endtask

  task automatic run_ext(int c, bit o, bit y, int e, int nb, string r);
    int k, eb, last, j;
    @(posedge clk);
    #1;
    src_sel = 2'd3; cd = c[15:0]; over_x8 = o; sync_mode = y;
    k = cyc;
    cur_req = r;
    s_cnt = 0;
    eb = c * (y ? 1 : (o ? 8 : 16));
    for (int m = 1; m <= nb; m++) begin
      exp_q.push_back(k + 2 + (m * eb - 1) * e + 2);
      req_q.push_back(r);
    end
    last = k + 2 + (nb * eb - 1) * e + 2;
    s_end = last;
    for (int i = 1; i <= nb * eb; i++) begin
      j = k + 2 + (i - 1) * e;
      at_cyc(j);
      ext_clk = 1'b1;
      at_cyc(j + e / 2);
      ext_clk = 1'b0;
    end
    finish_run(nb, o, y, r, last);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int last;
    repeat (3) @(negedge clk);
    check(!sample_tick && !bit_tick, "R10 reset outputs low", {sample_tick, bit_tick}, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    // R7: divisor zero, no ticks
    run_cfg(0, 0, 1'b0, 1'b0, 0, "R7 cd zero", last);
    // R2 R3 R4: 38,400 example, 96 cycles per bit
    run_cfg(0, 6, 1'b0, 1'b0, 3, "R4 cd6 x16", last);
    // R4: 39,062.5 example, 128 cycles per bit
    run_cfg(0, 8, 1'b0, 1'b0, 2, "R4 cd8 x16", last);
    // R2 R3: eight-times oversampling
    run_cfg(0, 5, 1'b1, 1'b0, 3, "R2 cd5 x8", last);
    // R4: fastest rate
    run_cfg(0, 1, 1'b1, 1'b0, 4, "R4 cd1 x8 max rate", last);
    // R1: prescaled source
    run_cfg(1, 3, 1'b1, 1'b0, 2, "R1 prescaled cd3 x8", last);
    // R6: synchronous mode
    run_cfg(0, 7, 1'b0, 1'b1, 4, "R6 sync cd7", last);
    // R8: reserved source
    run_cfg(2, 4, 1'b0, 1'b0, 0, "R8 reserved source", last);
    // R9: change in mid-period restarts the count
    run_cfg(0, 6, 1'b0, 1'b0, 2, "R9 before mid change", last);
    at_cyc(last + 49);
    run_cfg(0, 4, 1'b0, 1'b0, 2, "R9 after mid change", last);
    // R9: change lands on the cycle of a due tick (old period 64)
    at_cyc(last + 63);
    run_cfg(0, 3, 1'b1, 1'b0, 2, "R9 change on tick cycle", last);
    // R5: external pin, async and sync
    run_ext(2, 1'b1, 1'b0, 6, 2, "R5 ext cd2 x8");
    run_ext(3, 1'b0, 1'b1, 8, 3, "R5 ext sync cd3");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule